// File: doc/BRIEF.md
# TLB Support-Register Access Unit

This block holds the support-register file through which software maintains a set-associative translation buffer. Each move request names a support register and either writes 32-bit data into it or reads it back. The active bank of sixteen support registers is chosen by a separately loaded bank number. Two of the four banks own a private TLB array of four sets by sixteen entries. In those banks, writes to the high and low mirror registers stage and commit entries, and reads refresh the mirrors from the entry that the select register points at.

Requests enter on a valid/ready channel. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. Read data leaves on a second valid/ready channel. `req_ready` is low only while a response is held because `rsp_ready` is low, so a stalled consumer blocks every new request, writes included. When a low-mirror commit replaces an entry, a one-cycle strobe carries the page address of the mapping being replaced, so that cached translations of that page can be dropped.

Top module: `tlb_sreg_unit`

## Requirements
- R1: The active bank is the value last loaded through `bank_load`/`bank_value` (0 after reset). A bank load does not affect a request accepted in the same cycle.
- R2: In banks 0 and 3, all sixteen registers are plain storage. Each bank keeps its own copy of every register, no TLB entry changes and no invalidate is raised.
- R3: In bank 1 or 2, a write to register 6 (high mirror) stores the data in register 6 and also in register 3 (cause) of that bank.
- R4: In bank 1 or 2, a write to register 5 (low mirror) stores the data in register 5 and commits the entry {hi = cause register, lo = written data}. The entry is at set = select register (register 2) bits [5:4] and index = bits [3:0].
- R5: A commit from R4 raises `inval_valid` for exactly the cycle after acceptance. `inval_vaddr` then holds the replaced entry's hi word with bits [PAGE_BITS-1:0] cleared (PAGE_BITS = 13).
- R6: In bank 1 or 2, any read first loads registers 6 and 5 with the hi and lo words of the selected entry. The read then returns the requested register, so reads of 6 or 5 return the refreshed values. The cause and select registers are untouched.
- R7: A read response appears on `rsp_valid` the cycle after acceptance and holds its data until `rsp_ready` is high. `req_ready` equals `!rsp_valid || rsp_ready`.
- R8: Reset clears every support register, every TLB entry, the bank number and both output channels.
- R9: Bank 1 and bank 2 use separate TLB arrays, so a commit in one is never visible from the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_load | input | 1 | Load `bank_value` as the active bank |
| bank_value | input | 2 | New bank number |
| req_valid | input | 1 | Move request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write register, 0 = read register |
| req_reg | input | 4 | Support register number |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Consumer takes read data |
| rsp_data | output | 32 | Read data |
| inval_valid | output | 1 | One-cycle page invalidate strobe |
| inval_vaddr | output | 32 | Page address of the replaced mapping |

## Verification
The hardest case to reach is an invalidate whose address comes from an entry committed earlier, after the high mirror and cause register have since moved to other values. This needs a chain of select, high and low writes, a read that refreshes the mirrors, and then a second high write before the next low commit. The vector table builds that chain on one entry of bank 1. It then repeats part of it in bank 2 and checks that neither array leaks into the other. Directed steps hold the response channel with `rsp_ready` low while a write waits, and reset the block after the TLBs hold data.

// File: rtl/tlbsr_pkg.sv
package tlbsr_pkg;
  localparam int DATA_W   = 32;
  localparam int NUM_W    = 4;
  localparam int BANK_W   = 2;
  localparam int SET_W    = 2;
  localparam int IDX_W    = 4;
  localparam int REG_SEL  = 2;
  localparam int REG_CAUSE = 3;
  localparam int REG_LO   = 5;
  localparam int REG_HI   = 6;

  typedef struct packed {
    logic [DATA_W-1:0] hi;
    logic [DATA_W-1:0] lo;
  } tlb_entry_t;
endpackage

// File: rtl/tlbsr_regfile.sv
module tlbsr_regfile
  import tlbsr_pkg::*;
#(
  parameter int SEL_USE_W = SET_W + IDX_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [BANK_W-1:0]    bank,
  input  logic                 we_a,
  input  logic [NUM_W-1:0]     num_a,
  input  logic [DATA_W-1:0]    data_a,
  input  logic                 we_b,
  input  logic [NUM_W-1:0]     num_b,
  input  logic [DATA_W-1:0]    data_b,
  input  logic [NUM_W-1:0]     rd_num,
  output logic [DATA_W-1:0]    rd_data,
  output logic [SEL_USE_W-1:0] sel_q,
  output logic [DATA_W-1:0]    cause_q
);
  localparam int NBANK = 1 << BANK_W;
  localparam int NREG  = 1 << NUM_W;

  logic [DATA_W-1:0] regs [NBANK][NREG];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    for (genvar r = 0; r < NREG; r++) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          regs[b][r] <= '0;
        end else if (bank == BANK_W'(b)) begin
          if (we_b && num_b == NUM_W'(r))
            regs[b][r] <= data_b;
          else if (we_a && num_a == NUM_W'(r))
            regs[b][r] <= data_a;
        end
      end
    end
  end

  assign rd_data = regs[bank][rd_num];
  assign sel_q   = regs[bank][REG_SEL][SEL_USE_W-1:0];
  assign cause_q = regs[bank][REG_CAUSE];
endmodule

// File: rtl/tlbsr_tlb_store.sv
module tlbsr_tlb_store
  import tlbsr_pkg::*;
#(
  parameter int NARR = 2,
  localparam int ARR_W = (NARR > 1) ? $clog2(NARR) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [ARR_W-1:0] arr,
  input  logic [SET_W-1:0] set_i,
  input  logic [IDX_W-1:0] idx_i,
  input  tlb_entry_t       wentry,
  output tlb_entry_t       rentry
);
  localparam int NSET = 1 << SET_W;
  localparam int NIDX = 1 << IDX_W;

  tlb_entry_t mem [NARR][NSET][NIDX];

  for (genvar a = 0; a < NARR; a++) begin : g_arr
    for (genvar s = 0; s < NSET; s++) begin : g_set
      for (genvar i = 0; i < NIDX; i++) begin : g_ent
        always_ff @(posedge clk) begin
          if (!rst_n)
            mem[a][s][i] <= '0;
          else if (we && arr == ARR_W'(a) && set_i == SET_W'(s) && idx_i == IDX_W'(i))
            mem[a][s][i] <= wentry;
        end
      end
    end
  end

  assign rentry = mem[arr][set_i][idx_i];
endmodule

// File: rtl/tlb_sreg_unit.sv
module tlb_sreg_unit
  import tlbsr_pkg::*;
#(
  parameter int PAGE_BITS = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_load,
  input  logic [BANK_W-1:0] bank_value,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [NUM_W-1:0]  req_reg,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              inval_valid,
  output logic [DATA_W-1:0] inval_vaddr
);
  localparam int SEL_USE_W = SET_W + IDX_W;
  localparam logic [NUM_W-1:0] N_HI    = NUM_W'(REG_HI);
  localparam logic [NUM_W-1:0] N_LO    = NUM_W'(REG_LO);
  localparam logic [NUM_W-1:0] N_CAUSE = NUM_W'(REG_CAUSE);

  logic [BANK_W-1:0] bank_q;
  logic              tlb_bank;
  logic              acc;

  logic                 wa_en, wb_en;
  logic [NUM_W-1:0]     wa_num, wb_num;
  logic [DATA_W-1:0]    wa_data, wb_data;
  logic [DATA_W-1:0]    rf_rd;
  logic [SEL_USE_W-1:0] sel_q;
  logic [DATA_W-1:0]    cause_q;

  logic       tlb_we;
  tlb_entry_t cur_entry;
  tlb_entry_t new_entry;

  logic [DATA_W-1:0] rd_val;
  logic              inval_d;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_data_q;
  logic              inval_valid_q;
  logic [DATA_W-1:0] inval_vaddr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      bank_q <= '0;
    else if (bank_load)
      bank_q <= bank_value;
  end

  assign tlb_bank  = (bank_q == BANK_W'(1)) || (bank_q == BANK_W'(2));
  assign req_ready = !rsp_valid_q || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign new_entry = '{hi: cause_q, lo: req_wdata};

  tlbsr_regfile #(.SEL_USE_W(SEL_USE_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .bank    (bank_q),
    .we_a    (wa_en),
    .num_a   (wa_num),
    .data_a  (wa_data),
    .we_b    (wb_en),
    .num_b   (wb_num),
    .data_b  (wb_data),
    .rd_num  (req_reg),
    .rd_data (rf_rd),
    .sel_q   (sel_q),
    .cause_q (cause_q)
  );

  tlbsr_tlb_store #(.NARR(2)) u_tlb (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (tlb_we),
    .arr    (bank_q[1]),
    .set_i  (sel_q[SEL_USE_W-1:IDX_W]),
    .idx_i  (sel_q[IDX_W-1:0]),
    .wentry (new_entry),
    .rentry (cur_entry)
  );

  always_comb begin
    wa_en   = 1'b0;
    wa_num  = req_reg;
    wa_data = req_wdata;
    wb_en   = 1'b0;
    wb_num  = N_CAUSE;
    wb_data = req_wdata;
    tlb_we  = 1'b0;
    inval_d = 1'b0;
    if (acc) begin
      if (req_write) begin
        wa_en = 1'b1;
        if (tlb_bank && req_reg == N_HI) begin
          wb_en = 1'b1;
        end else if (tlb_bank && req_reg == N_LO) begin
          tlb_we  = 1'b1;
          inval_d = 1'b1;
        end
      end else if (tlb_bank) begin
        wa_en   = 1'b1;
        wa_num  = N_HI;
        wa_data = cur_entry.hi;
        wb_en   = 1'b1;
        wb_num  = N_LO;
        wb_data = cur_entry.lo;
      end
    end
  end

  always_comb begin
    if (tlb_bank && req_reg == N_HI)
      rd_val = cur_entry.hi;
    else if (tlb_bank && req_reg == N_LO)
      rd_val = cur_entry.lo;
    else
      rd_val = rf_rd;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else if (acc && !req_write) begin
      rsp_valid_q <= 1'b1;
      rsp_data_q  <= rd_val;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inval_valid_q <= 1'b0;
      inval_vaddr_q <= '0;
    end else begin
      inval_valid_q <= inval_d;
      if (inval_d)
        inval_vaddr_q <= {cur_entry.hi[DATA_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
    end
  end

  assign rsp_valid   = rsp_valid_q;
  assign rsp_data    = rsp_data_q;
  assign inval_valid = inval_valid_q;
  assign inval_vaddr = inval_vaddr_q;
endmodule

// File: rtl/tlbsr_checker.sv
module tlbsr_checker
  import tlbsr_pkg::*;
#(
  parameter int PAGE_BITS = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [NUM_W-1:0]  req_reg,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic              inval_valid,
  input logic [DATA_W-1:0] inval_vaddr,
  input logic [BANK_W-1:0] bank_q
);
  a_r5_inval_source: assert property (@(posedge clk) disable iff (!rst_n)
    inval_valid |-> $past(req_valid && req_ready && req_write &&
                          req_reg == NUM_W'(REG_LO) &&
                          (bank_q == BANK_W'(1) || bank_q == BANK_W'(2))));

  a_r5_page_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    inval_valid |-> (inval_vaddr[PAGE_BITS-1:0] == '0));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  a_r7_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  a_r7_rsp_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(req_valid && req_ready && !req_write));
endmodule

bind tlb_sreg_unit tlbsr_checker #(.PAGE_BITS(PAGE_BITS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_write   (req_write),
  .req_reg     (req_reg),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_data    (rsp_data),
  .inval_valid (inval_valid),
  .inval_vaddr (inval_vaddr),
  .bank_q      (bank_q)
);

// File: tb/tlb_sreg_unit_test.sv
`timescale 1ns/1ps
module tlb_sreg_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bank_load = 1'b0;
  logic [1:0]  bank_value = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [3:0]  req_reg = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_data;
  logic        inval_valid;
  logic [31:0] inval_vaddr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tlb_sreg_unit uut (
    .clk(clk), .rst_n(rst_n), .bank_load(bank_load), .bank_value(bank_value),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_reg(req_reg), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .inval_valid(inval_valid),
    .inval_vaddr(inval_vaddr)
  );

  // kinds: 0 bank load, 1 write (no invalidate), 2 write with invalidate, 3 read
  localparam int NV = 41;
  localparam logic [75:0] VEC [NV] = '{
    {4'd1, 4'd0, 4'd0, 32'h0000_0000, 32'h0},            // R1 bank 0
    {4'd2, 4'd1, 4'd6, 32'hAAAA_0000, 32'h0},            // R2
    {4'd2, 4'd1, 4'd5, 32'h0000_1111, 32'h0},            // R2 no invalidate
    {4'd2, 4'd3, 4'd6, 32'h0, 32'hAAAA_0000},            // R2
    {4'd2, 4'd3, 4'd3, 32'h0, 32'h0000_0000},            // R2 cause untouched
    {4'd2, 4'd3, 4'd5, 32'h0, 32'h0000_1111},            // R2
    {4'd1, 4'd0, 4'd0, 32'h0000_0001, 32'h0},            // R1 bank 1
    {4'd6, 4'd3, 4'd6, 32'h0, 32'h0000_0000},            // R6
    {4'd4, 4'd1, 4'd2, 32'h0000_0025, 32'h0},            // R4 set 2 idx 5
    {4'd3, 4'd1, 4'd6, 32'h1234_E000, 32'h0},            // R3
    {4'd3, 4'd3, 4'd3, 32'h0, 32'h1234_E000},            // R3 cause copy
    {4'd5, 4'd2, 4'd5, 32'hCAFE_0001, 32'h0000_0000},    // R5
    {4'd3, 4'd1, 4'd6, 32'h5555_5555, 32'h0},            // R3
    {4'd4, 4'd3, 4'd6, 32'h0, 32'h1234_E000},            // R4 committed hi
    {4'd4, 4'd3, 4'd5, 32'h0, 32'hCAFE_0001},            // R4 committed lo
    {4'd6, 4'd3, 4'd3, 32'h0, 32'h5555_5555},            // R6 cause not refreshed
    {4'd5, 4'd2, 4'd5, 32'h0000_7777, 32'h1234_E000},    // R5 old mapping
    {4'd6, 4'd3, 4'd6, 32'h0, 32'h5555_5555},            // R6
    {4'd5, 4'd2, 4'd5, 32'h0000_0008, 32'h5555_4000},    // R5 page clear
    {4'd4, 4'd1, 4'd2, 32'h0000_0005, 32'h0},            // R4 set 0
    {4'd4, 4'd3, 4'd6, 32'h0, 32'h0000_0000},            // R4
    {4'd4, 4'd1, 4'd2, 32'h0000_003F, 32'h0},            // R4 set 3 idx 15
    {4'd4, 4'd3, 4'd5, 32'h0, 32'h0000_0000},            // R4
    {4'd1, 4'd0, 4'd0, 32'h0000_0002, 32'h0},            // R1 bank 2
    {4'd9, 4'd1, 4'd2, 32'h0000_0025, 32'h0},            // R9
    {4'd9, 4'd3, 4'd6, 32'h0, 32'h0000_0000},            // R9 separate array
    {4'd3, 4'd1, 4'd6, 32'hABCD_E123, 32'h0},            // R3
    {4'd5, 4'd2, 4'd5, 32'h0000_0042, 32'h0000_0000},    // R5
    {4'd6, 4'd3, 4'd5, 32'h0, 32'h0000_0042},            // R6
    {4'd6, 4'd3, 4'd6, 32'h0, 32'hABCD_E123},            // R6
    {4'd1, 4'd0, 4'd0, 32'h0000_0001, 32'h0},            // R1 bank 1
    {4'd2, 4'd3, 4'd2, 32'h0, 32'h0000_003F},            // R2 select kept per bank
    {4'd4, 4'd1, 4'd2, 32'h0000_0025, 32'h0},            // R4
    {4'd9, 4'd3, 4'd6, 32'h0, 32'h5555_5555},            // R9
    {4'd9, 4'd3, 4'd5, 32'h0, 32'h0000_0008},            // R9
    {4'd1, 4'd0, 4'd0, 32'h0000_0003, 32'h0},            // R1 bank 3
    {4'd2, 4'd1, 4'd5, 32'h0000_0099, 32'h0},            // R2 no invalidate
    {4'd2, 4'd3, 4'd5, 32'h0, 32'h0000_0099},            // R2
    {4'd2, 4'd3, 4'd6, 32'h0, 32'h0000_0000},            // R2 no refresh
    {4'd1, 4'd0, 4'd0, 32'h0000_0000, 32'h0},            // R1 bank 0
    {4'd2, 4'd3, 4'd6, 32'h0, 32'hAAAA_0000}             // R2
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load_bank(input logic [1:0] v);
    @(negedge clk);
    bank_load = 1'b1;
    bank_value = v;
    @(posedge clk);
    #1;
    bank_load = 1'b0;
  endtask

  // Returns after the accepting edge, with registered outputs settled.
  task automatic issue(input logic w, input logic [3:0] r, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1;
    req_write = w;
    req_reg = r;
    req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R8 reset state
    check("R8 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    check("R8 inval_valid", {31'd0, inval_valid}, 32'd0);
    check("R7 req_ready", {31'd0, req_ready}, 32'd1);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      automatic logic [3:0]  tag  = VEC[i][75:72];
      automatic logic [3:0]  kind = VEC[i][71:68];
      automatic logic [3:0]  rg   = VEC[i][67:64];
      automatic logic [31:0] dat  = VEC[i][63:32];
      automatic logic [31:0] exp  = VEC[i][31:0];
      automatic string t = $sformatf("R%0d vec%0d", tag, i);
      case (kind)
        4'd0: load_bank(dat[1:0]);
        4'd1: begin
          issue(1'b1, rg, dat);
          check(t, {31'd0, inval_valid}, 32'd0);
        end
        4'd2: begin
          issue(1'b1, rg, dat);
          check(t, {31'd0, inval_valid}, 32'd1);
          check(t, inval_vaddr, exp);
        end
        default: begin
          issue(1'b0, rg, dat);
          check(t, {31'd0, rsp_valid}, 32'd1);
          check(t, rsp_data, exp);
        end
      endcase
    end

    // R5 strobe lasts one cycle only
    load_bank(2'd1);
    issue(1'b1, 4'd5, 32'h0000_0123);
    check("R5 strobe", {31'd0, inval_valid}, 32'd1);
    @(posedge clk); #1;
    check("R5 one cycle", {31'd0, inval_valid}, 32'd0);

    // R7 back-pressure in bank 0
    load_bank(2'd0);
    @(negedge clk);
    rsp_ready = 1'b0;
    issue(1'b0, 4'd6, 32'h0);
    check("R7 rsp_valid", {31'd0, rsp_valid}, 32'd1);
    check("R7 data", rsp_data, 32'hAAAA_0000);
    @(negedge clk);
    check("R7 ready low", {31'd0, req_ready}, 32'd0);
    req_valid = 1'b1;
    req_write = 1'b1;
    req_reg = 4'd6;
    req_wdata = 32'h0BAD_0BAD;
    @(posedge clk); #1;
    check("R7 held valid", {31'd0, rsp_valid}, 32'd1);
    check("R7 held data", rsp_data, 32'hAAAA_0000);
    @(negedge clk);
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    @(posedge clk); #1;
    check("R7 drained", {31'd0, rsp_valid}, 32'd0);
    issue(1'b0, 4'd6, 32'h0);
    check("R7 blocked write dropped", rsp_data, 32'hAAAA_0000);

    // R8 reset clears registers, bank and TLB contents
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check("R8 rsp after reset", {31'd0, rsp_valid}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    issue(1'b0, 4'd6, 32'h0);
    check("R8 bank0 reg cleared", rsp_data, 32'h0);
    load_bank(2'd1);
    issue(1'b1, 4'd2, 32'h0000_0025);
    issue(1'b0, 4'd5, 32'h0);
    check("R8 tlb cleared", rsp_data, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule